// File: doc/BRIEF.md
# Dual Halfword Saturator with Sticky Overflow Flag

This block takes a 32-bit word holding two signed 16-bit lanes and clamps each lane on its own to a range chosen per operation. In signed mode the range is -2^(n-1) to 2^(n-1)-1. In unsigned mode the range is 0 to 2^n-1. The value n comes from a width field supplied with the operand. The two clamped lanes are packed back into one 32-bit result.

Whenever either lane has to be clamped, a sticky overflow flag is set. The flag sits at bit 27 of a 32-bit status word. Later operations that clamp nothing leave the flag as it is. Only reset or the dedicated clear input brings it back to zero.

A small two-state controller sequences the result. In state IDLE no result is being presented. The transition "accept" (in_valid high) moves IDLE to DONE. The transition "accept again" (in_valid high while in DONE) keeps the controller in DONE for back-to-back operands. The transition "retire" (in_valid low while in DONE) returns it to IDLE. The done output is high exactly while the controller is in DONE. The result register and the flag update on the same edge that samples in_valid.

Top module: `dual_half_clamp`

## Requirements
- R1: Bits 15:0 of in_word form the low lane and bits 31:16 form the high lane. Each lane is clamped independently, and the result carries the low lane in bits 15:0 and the high lane in bits 31:16.
- R2: With mode_unsigned = 0, a lane greater than 2^(n-1)-1 becomes 2^(n-1)-1, a lane less than -2^(n-1) becomes -2^(n-1), and any other lane passes through unchanged.
- R3: With mode_unsigned = 1, a lane greater than 2^n-1 becomes 2^n-1, a negative lane becomes 0, and any other lane passes through unchanged.
- R4: The field sat_width gives n. In signed mode a value of 0 is taken as 1 and a value above 16 is taken as 16. In unsigned mode a value above 15 is taken as 15, and 0 gives a range of just 0.
- R5: An accepted operation that clamps either lane, in either direction, sets the flag at bit 27 of status_word. All other status bits always read 0.
- R6: An accepted operation that clamps neither lane leaves the flag unchanged.
- R7: When q_clear is high at a clock edge, the flag is 0 after that edge. This holds even if an operation accepted at the same edge clamps. Reset also clears the flag.
- R8: The result of an operand accepted at one edge appears on out_word after that edge, and out_done is high for that cycle. When in_valid is low at an edge, out_done is low after it and out_word holds its value.
- R9: After reset, out_word is 0, out_done is 0 and status_word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe; the operand is sampled at the edge |
| in_word | input | 32 | Two packed signed 16-bit lanes |
| mode_unsigned | input | 1 | 0 = signed range, 1 = unsigned range |
| sat_width | input | 5 | Saturation width n |
| q_clear | input | 1 | Clears the sticky flag; wins over a same-edge set |
| out_word | output | 32 | Packed clamped result |
| out_done | output | 1 | High for one cycle per accepted operand |
| status_word | output | 32 | Bit 27 holds the sticky flag; the rest read 0 |

## Verification
The bench aims at the range edges. These are values one step inside and one step outside 2^(n-1)-1 and -2^(n-1), the single-bit signed range of -1 to 0, and the unsigned width of 0. A design with an off-by-one bound would pass or clip a value at exactly the wrong step. A design that confused lanes or sign-extended the wrong half would clip the other lane or corrupt the packing. The bench also drives out-of-range width codes, which a design without proper width handling would turn into shifts that wrap. Finally, it drives a non-clamping operation after a clamp and a clear in the same cycle as a clamp. A flag that is not truly sticky would drop in the first case, and one that lets the set win would stay up in the second.

// File: rtl/hsat_pkg.sv
package hsat_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } hsat_state_e;

    localparam int STATUS_W  = 32;
    localparam int Q_BIT_POS = 27;
endpackage

// File: rtl/hsat_width_norm.sv
module hsat_width_norm #(
    parameter int LANE_W = 16,
    parameter int NW     = 5
) (
    input  logic [NW-1:0] raw_width,
    input  logic          is_unsigned,
    output logic [NW-1:0] eff_width
);
    localparam logic [NW-1:0] SMAX = NW'(LANE_W);
    localparam logic [NW-1:0] UMAX = NW'(LANE_W - 1);

    always_comb begin
        eff_width = raw_width;
        if (is_unsigned) begin
            if (raw_width > UMAX) eff_width = UMAX;
        end else begin
            if (raw_width == '0)       eff_width = NW'(1);
            else if (raw_width > SMAX) eff_width = SMAX;
        end
    end
endmodule

// File: rtl/hsat_lane.sv
module hsat_lane #(
    parameter int LANE_W = 16,
    parameter int NW     = 5
) (
    input  logic [LANE_W-1:0] lane_in,
    input  logic              is_unsigned,
    input  logic [NW-1:0]     eff_width,
    output logic [LANE_W-1:0] lane_out,
    output logic              clipped
);
    localparam int EW = LANE_W + 2;

    logic signed [EW-1:0] val;
    logic signed [EW-1:0] step;
    logic signed [EW-1:0] hi;
    logic signed [EW-1:0] lo;
    logic [NW-1:0]        shamt;

    always_comb begin
        val   = {{2{lane_in[LANE_W-1]}}, lane_in};
        shamt = is_unsigned ? eff_width : (eff_width - NW'(1));
        step  = EW'(1) << shamt;
        hi    = step - EW'(1);
        lo    = is_unsigned ? '0 : -step;
        if (val > hi) begin
            lane_out = hi[LANE_W-1:0];
            clipped  = 1'b1;
        end else if (val < lo) begin
            lane_out = lo[LANE_W-1:0];
            clipped  = 1'b1;
        end else begin
            lane_out = lane_in;
            clipped  = 1'b0;
        end
        // R3: unsigned mode never yields a value with the sign bit set
        assert_unsigned_nonneg_R3: assert (!is_unsigned || !lane_out[LANE_W-1]);
    end
endmodule

// File: rtl/hsat_sticky.sv
module hsat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (clr_i) q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
    end

    assert_q_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> q_o);
    assert_q_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));
    assert_q_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);
endmodule

// File: rtl/dual_half_clamp.sv
module dual_half_clamp #(
    parameter int LANE_W = 16,
    parameter int LANES  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [LANE_W*LANES-1:0]         in_word,
    input  logic                            mode_unsigned,
    input  logic [$clog2(LANE_W):0]         sat_width,
    input  logic                            q_clear,
    output logic [LANE_W*LANES-1:0]         out_word,
    output logic                            out_done,
    output logic [hsat_pkg::STATUS_W-1:0]   status_word
);
    import hsat_pkg::*;

    localparam int WORD_W = LANE_W * LANES;
    localparam int NW     = $clog2(LANE_W) + 1;

    logic [NW-1:0]     eff_width;
    logic [WORD_W-1:0] packed_res;
    logic [LANES-1:0]  lane_clip;
    logic              clip_any;
    logic              q_flag;

    hsat_width_norm #(.LANE_W(LANE_W), .NW(NW)) u_wnorm (
        .raw_width  (sat_width),
        .is_unsigned(mode_unsigned),
        .eff_width  (eff_width)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hsat_lane #(.LANE_W(LANE_W), .NW(NW)) u_lane (
            .lane_in    (in_word[g*LANE_W +: LANE_W]),
            .is_unsigned(mode_unsigned),
            .eff_width  (eff_width),
            .lane_out   (packed_res[g*LANE_W +: LANE_W]),
            .clipped    (lane_clip[g])
        );
    end

    assign clip_any = in_valid && (|lane_clip);

    hsat_sticky u_sticky (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(clip_any),
        .clr_i(q_clear),
        .q_o  (q_flag)
    );

    hsat_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_DONE;
            ST_DONE: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_word <= '0;
        else if (in_valid) out_word <= packed_res;
    end

    always_comb begin
        out_done                = (state_q == ST_DONE);
        status_word            = '0;
        status_word[Q_BIT_POS] = q_flag;
    end

    assert_done_after_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);
    assert_done_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_done && $stable(out_word)));
    assert_status_only_q_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status_word) <= 1);
endmodule

// File: tb/sim_dual_half_clamp.sv
module sim_dual_half_clamp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        mode_unsigned = 1'b0;
    logic [4:0]  sat_width = '0;
    logic        q_clear = 1'b0;
    logic [31:0] out_word;
    logic        out_done;
    logic [31:0] status_word;

    int checks = 0;
    int fails  = 0;
    bit model_q = 1'b0;
    bit finished = 1'b0;

    typedef struct { logic [31:0] word; logic [31:0] status; string tag; } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    dual_half_clamp u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .mode_unsigned(mode_unsigned), .sat_width(sat_width), .q_clear(q_clear),
        .out_word(out_word), .out_done(out_done), .status_word(status_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_lane(input logic [15:0] v, input bit uns,
                                               input int w, output bit clip);
        int s, n, hi, lo, r;
        s = int'($signed(v));
        if (uns) begin
            n = (w > 15) ? 15 : w;
            hi = (1 << n) - 1; lo = 0;
        end else begin
            n = (w == 0) ? 1 : ((w > 16) ? 16 : w);
            hi = (1 << (n - 1)) - 1; lo = -(1 << (n - 1));
        end
        clip = 1'b1;
        if (s > hi)      r = hi;
        else if (s < lo) r = lo;
        else begin r = s; clip = 1'b0; end
        return r[15:0];
    endfunction

    task automatic drive(input string tag, input logic [31:0] w, input bit uns,
                         input int width, input bit clr);
        exp_t e;
        bit c0, c1;
        logic [15:0] l0, l1;
        @(negedge clk);
        in_valid = 1'b1; in_word = w; mode_unsigned = uns;
        sat_width = 5'(width); q_clear = clr;
        l0 = model_lane(w[15:0], uns, width, c0);
        l1 = model_lane(w[31:16], uns, width, c1);
        if (clr) model_q = 1'b0;
        else if (c0 || c1) model_q = 1'b1;
        e.word = {l1, l0};
        e.status = 32'(model_q) << 27;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input bit clr);
        @(negedge clk);
        in_valid = 1'b0; q_clear = clr;
        if (clr) model_q = 1'b0;
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && out_done) begin
            if (sb.size() == 0) begin
                check("R8 unexpected done", 32'(out_done), 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " word"}, out_word, e.word);
                check({e.tag, " status"}, status_word, e.status);
            end
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check("R9 reset word", out_word, 32'h0);
        check("R9 reset done", 32'(out_done), 32'h0);
        check("R9 reset status", status_word, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        drive("R1 R6 signed n16 passthrough", 32'h8000_7FFF, 1'b0, 16, 1'b0);
        drive("R2 R1 signed n8 high clip/low pass", 32'h0080_FF80, 1'b0, 8, 1'b0);
        drive("R2 signed n8 edges", 32'hFF7F_007F, 1'b0, 8, 1'b0);
        drive("R2 signed n8 low clip negative", 32'h0000_FF7F, 1'b0, 8, 1'b0);
        idle(1'b1);
        idle(1'b0);
        check("R7 clear alone", status_word, 32'h0);
        drive("R2 signed n1", 32'hFFFF_0001, 1'b0, 1, 1'b0);
        drive("R6 nonclip keeps flag", 32'h0000_0000, 1'b0, 4, 1'b0);
        drive("R7 clear beats clip", 32'h7FFF_8000, 1'b0, 2, 1'b1);
        drive("R4 signed width0 as 1", 32'hFFFE_0000, 1'b0, 0, 1'b0);
        drive("R4 signed width20 as 16", 32'h8000_7FFF, 1'b0, 20, 1'b1);
        drive("R4 signed width17 as 16", 32'h1234_ABCD, 1'b0, 17, 1'b0);
        drive("R3 unsigned n8", 32'h0100_00FF, 1'b0 | 1'b1, 8, 1'b0);
        drive("R3 unsigned negative to 0", 32'hFFFF_8000, 1'b1, 8, 1'b1);
        drive("R3 R4 unsigned n0", 32'h0000_0001, 1'b1, 0, 1'b1);
        drive("R4 unsigned width31 as 15", 32'h7FFF_0005, 1'b1, 31, 1'b1);
        drive("R4 unsigned width16 as 15", 32'h8000_7FFF, 1'b1, 16, 1'b1);
        drive("R5 unsigned low only clip", 32'h0003_0010, 1'b1, 4, 1'b0);
        idle(1'b0);
        held = out_word;
        idle(1'b0);
        check("R8 done low when idle", 32'(out_done), 32'h0);
        check("R8 word holds", out_word, held);
        check("R6 flag holds while idle", status_word, 32'h0800_0000);
        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", 32'(sb.size()), 32'h0);
        finish_run();
    end
endmodule